// File: doc/BRIEF.md
# Exception Escalation Resolver

This block sits between the exception sources of a processor core and the delivery sequencer that builds the stack frame. Each cycle it may receive one raised exception vector with a raw error code. It sorts the vector into one of three severity classes and compares that class with the class of the exception that is still being delivered. From this comparison it decides one of three outcomes: deliver the vector unchanged, replace it with the double-fault vector 8, or request a processor shutdown (triple fault).

For every delivered vector the block also produces the error code word and a flag that says whether that word is pushed. It forces the code to zero in real mode, and it sets bit 0 of the code to show that the event came from outside the instruction stream. It also reports whether the return address must point back at the faulting instruction. The delivery sequencer pulses a completion strobe when the frame is written. The strobe returns the block to its idle, benign state.

All results are registered. They appear exactly one clock after the raise is sampled. A vector outside the architectural range 0 to 31 produces only an "illegal" pulse.

Top module: `exc_fault_resolver`

## Requirements
- R1: A legal raise (vector below 32) that causes neither promotion nor shutdown produces `dlv_valid` high for one cycle, one clock after the raise is sampled, with `dlv_vec` equal to the raised vector. With no raise, `dlv_valid`, `shutdown_req` and `vec_illegal` stay low.
- R2: The contributory class is vectors 0, 10, 11, 12 and 13. A contributory vector raised while the recorded class is contributory is delivered as vector 8 with error code 0 and push flag set (outside real mode).
- R3: The page-fault class is vectors 14 and 20. A contributory or page-fault vector raised while the recorded class is page-fault is delivered as vector 8. A page-fault vector raised while the recorded class is contributory is delivered unchanged. A benign vector is always delivered unchanged.
- R4: Outside real mode, `dlv_push_err` is 1 exactly for delivered vectors 8, 10, 11, 12, 13, 14 and 17.
- R5: Outside real mode, for raised vectors other than 8 and 14, `dlv_err` equals the raw code with bit 0 replaced by (`ext_in` OR "an earlier exception is still in delivery"). For vectors 8 and 14 the raw code is passed unchanged.
- R6: `dlv_restore_ip` is 0 for vectors 3, 4 (traps) and 18 (abort), and 1 for every other delivered vector, including a promoted vector 8.
- R7: A fault (any vector except 3, 4, 18) raised while the recorded class is double fault produces a one-cycle `shutdown_req` and no delivery. A trap raised in that state is delivered normally.
- R8: When `real_mode` is high at the raise, `dlv_push_err` is 0 and `dlv_err` is 0. Promotion still applies.
- R9: `deliver_done` returns the recorded class to benign and clears the in-delivery state. A raise in the same cycle as `deliver_done` is judged against the cleared state.
- R10: A raised vector of 32 or above produces a one-cycle `vec_illegal` pulse, no delivery, no shutdown, and leaves the recorded class unchanged.
- R11: The recorded class is updated to the class of each delivered vector unless that vector is benign, in which case the previous class is kept. After reset the class is benign and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raise_valid | input | 1 | A new exception is raised this cycle |
| raise_vec | input | 8 | Raised exception vector |
| raise_err | input | 16 | Raw error code of the raised exception |
| ext_in | input | 1 | External-event indication for the error code |
| real_mode | input | 1 | Processor is in real-address mode |
| deliver_done | input | 1 | Delivery sequencer finished the current frame |
| dlv_valid | output | 1 | One-cycle strobe: a vector is to be delivered |
| dlv_vec | output | 8 | Vector to deliver (raised vector or 8) |
| dlv_err | output | 16 | Formatted error code |
| dlv_push_err | output | 1 | Error code is pushed on the stack |
| dlv_restore_ip | output | 1 | Return address is the faulting instruction |
| shutdown_req | output | 1 | One-cycle triple-fault shutdown request |
| vec_illegal | output | 1 | One-cycle strobe: raised vector out of range |

## Verification
The escalation matrix is tried with ordered pairs of raises and no completion between them. These pairs are contributory then contributory, page-fault then page-fault, page-fault then benign, and contributory then page-fault. The pairs separate promotion from pass-through, so a matrix cell that is swapped or missing shows up as the wrong vector. Raises made while the double-fault class is held separate the fault path (shutdown) from the trap path (delivery).

Error-code formatting is tried with a set of code patterns. The patterns put different values in bit 0 under different external flags, both with and without an exception in delivery. They show whether bit 0 is replaced or kept, and whether real mode clears both the code and the push flag.

A raise in the same cycle as a completion strobe shows the order in which the strobe and the raise are applied. An out-of-range raise followed by a contributory raise shows that the recorded class is left unchanged.

// File: rtl/exc_esc_pkg.sv
package exc_esc_pkg;

  // Severity class recorded for the exception in delivery.
  typedef enum logic [1:0] {
    CLS_BENIGN  = 2'd0,
    CLS_CONTRIB = 2'd1,
    CLS_PAGE    = 2'd2,
    CLS_DOUBLE  = 2'd3
  } exc_cls_e;

endpackage

// File: rtl/exc_vec_classify.sv
module exc_vec_classify
  import exc_esc_pkg::*;
#(
  parameter int          VEC_W      = 8,
  parameter int          NUM_VEC    = 32,
  parameter int          DF_VEC     = 8,
  parameter logic [31:0] CONTRIB_MK = 32'h0000_3C01,
  parameter logic [31:0] PAGE_MK    = 32'h0010_4000,
  parameter logic [31:0] ERRPUSH_MK = 32'h0002_7D00,
  parameter logic [31:0] RAWBIT0_MK = 32'h0000_4100,
  parameter logic [31:0] NOFAULT_MK = 32'h0004_0018
) (
  input  logic [VEC_W-1:0] vec,
  output logic             legal,
  output exc_cls_e         cls,
  output logic             has_err,
  output logic             keep_bit0,
  output logic             is_fault
);
  localparam int IDX_W = $clog2(NUM_VEC);

  logic [IDX_W-1:0] idx;

  assign idx       = vec[IDX_W-1:0];
  assign legal     = (vec < VEC_W'(NUM_VEC));
  assign has_err   = ERRPUSH_MK[idx];
  assign keep_bit0 = RAWBIT0_MK[idx];
  assign is_fault  = !NOFAULT_MK[idx];

  always_comb begin
    if (idx == IDX_W'(DF_VEC))  cls = CLS_DOUBLE;
    else if (CONTRIB_MK[idx])   cls = CLS_CONTRIB;
    else if (PAGE_MK[idx])      cls = CLS_PAGE;
    else                        cls = CLS_BENIGN;
  end

endmodule

// File: rtl/exc_escalate.sv
module exc_escalate
  import exc_esc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     raise,
  input  logic     legal,
  input  exc_cls_e cls,
  input  logic     is_fault,
  input  logic     done,
  output logic     in_flight,
  output logic     promote,
  output logic     kill,
  output logic     accept
);
  exc_cls_e rec_q, rec_eff;
  logic     busy_q;

  // Completion in the same cycle is applied before the new raise is judged.
  assign rec_eff   = done ? CLS_BENIGN : rec_q;
  assign in_flight = done ? 1'b0 : busy_q;

  always_comb begin
    kill    = raise && legal && (rec_eff == CLS_DOUBLE) && is_fault;
    promote = 1'b0;
    if (raise && legal && !kill) begin
      unique case (rec_eff)
        CLS_CONTRIB: promote = (cls == CLS_CONTRIB);
        CLS_PAGE:    promote = (cls == CLS_CONTRIB) || (cls == CLS_PAGE);
        default:     promote = 1'b0;
      endcase
    end
    accept = raise && legal && !kill;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rec_q  <= CLS_BENIGN;
      busy_q <= 1'b0;
    end else if (accept) begin
      busy_q <= 1'b1;
      if (promote)                rec_q <= CLS_DOUBLE;
      else if (cls != CLS_BENIGN) rec_q <= cls;
      else                        rec_q <= rec_eff;
    end else begin
      rec_q  <= rec_eff;
      busy_q <= in_flight;
    end
  end

  a_r9_done_clears: assert property (@(posedge clk) disable iff (rst)
    (done && !raise) |=> (rec_q == CLS_BENIGN) && !busy_q);

  a_r2_promote_records_double: assert property (@(posedge clk) disable iff (rst)
    promote |=> (rec_q == CLS_DOUBLE) && busy_q);

  a_r7_kill_needs_double: assert property (@(posedge clk) disable iff (rst)
    kill |-> !promote && !accept);

  a_r10_illegal_keeps_class: assert property (@(posedge clk) disable iff (rst)
    (raise && !legal && !done) |=> $stable(rec_q));

endmodule

// File: rtl/exc_err_form.sv
module exc_err_form #(
  parameter int ERR_W = 16
) (
  input  logic [ERR_W-1:0] raw,
  input  logic             ext_bit,
  input  logic             keep_bit0,
  input  logic             has_err,
  input  logic             promote,
  input  logic             real_mode,
  output logic [ERR_W-1:0] err,
  output logic             push
);
  always_comb begin
    if (real_mode || promote) err = '0;
    else if (keep_bit0)       err = raw;
    else                      err = {raw[ERR_W-1:1], ext_bit};
    push = !real_mode && (promote || has_err);
  end

endmodule

// File: rtl/exc_fault_resolver.sv
module exc_fault_resolver
  import exc_esc_pkg::*;
#(
  parameter int VEC_W   = 8,
  parameter int ERR_W   = 16,
  parameter int NUM_VEC = 32,
  parameter int DF_VEC  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             raise_valid,
  input  logic [VEC_W-1:0] raise_vec,
  input  logic [ERR_W-1:0] raise_err,
  input  logic             ext_in,
  input  logic             real_mode,
  input  logic             deliver_done,
  output logic             dlv_valid,
  output logic [VEC_W-1:0] dlv_vec,
  output logic [ERR_W-1:0] dlv_err,
  output logic             dlv_push_err,
  output logic             dlv_restore_ip,
  output logic             shutdown_req,
  output logic             vec_illegal
);
  logic             legal, has_err, keep_bit0, is_fault;
  exc_cls_e         cls;
  logic             in_flight, promote, kill, accept;
  logic [ERR_W-1:0] err_c;
  logic             push_c;

  exc_vec_classify #(.VEC_W(VEC_W), .NUM_VEC(NUM_VEC), .DF_VEC(DF_VEC)) u_cls (
    .vec(raise_vec), .legal(legal), .cls(cls), .has_err(has_err),
    .keep_bit0(keep_bit0), .is_fault(is_fault)
  );

  exc_escalate u_esc (
    .clk(clk), .rst(rst), .raise(raise_valid), .legal(legal), .cls(cls),
    .is_fault(is_fault), .done(deliver_done), .in_flight(in_flight),
    .promote(promote), .kill(kill), .accept(accept)
  );

  exc_err_form #(.ERR_W(ERR_W)) u_err (
    .raw(raise_err), .ext_bit(ext_in | in_flight), .keep_bit0(keep_bit0),
    .has_err(has_err), .promote(promote), .real_mode(real_mode),
    .err(err_c), .push(push_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dlv_valid      <= 1'b0;
      dlv_vec        <= '0;
      dlv_err        <= '0;
      dlv_push_err   <= 1'b0;
      dlv_restore_ip <= 1'b0;
      shutdown_req   <= 1'b0;
      vec_illegal    <= 1'b0;
    end else begin
      dlv_valid    <= accept;
      shutdown_req <= kill;
      vec_illegal  <= raise_valid && !legal;
      if (accept) begin
        dlv_vec        <= promote ? VEC_W'(DF_VEC) : raise_vec;
        dlv_err        <= err_c;
        dlv_push_err   <= push_c;
        dlv_restore_ip <= promote || is_fault;
      end
    end
  end

  a_r7_no_deliver_on_shutdown: assert property (@(posedge clk) disable iff (rst)
    shutdown_req |-> !dlv_valid);

  a_r10_illegal_alone: assert property (@(posedge clk) disable iff (rst)
    vec_illegal |-> !dlv_valid && !shutdown_req);

  a_r8_real_mode_zero_code: assert property (@(posedge clk) disable iff (rst)
    (raise_valid && real_mode) |=> !dlv_push_err && (dlv_err == '0));

  a_r6_traps_no_restore: assert property (@(posedge clk) disable iff (rst)
    (dlv_valid && (dlv_vec == VEC_W'(3) || dlv_vec == VEC_W'(4) || dlv_vec == VEC_W'(18)))
      |-> !dlv_restore_ip);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !raise_valid |=> !dlv_valid && !shutdown_req && !vec_illegal);

endmodule

// File: tb/exc_fault_resolver_tb.sv
module exc_fault_resolver_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        raise_valid = 1'b0;
  logic [7:0]  raise_vec = '0;
  logic [15:0] raise_err = '0;
  logic        ext_in = 1'b0, real_mode = 1'b0, deliver_done = 1'b0;
  logic        dlv_valid, dlv_push_err, dlv_restore_ip, shutdown_req, vec_illegal;
  logic [7:0]  dlv_vec;
  logic [15:0] dlv_err;

  int n_cmp = 0, n_bad = 0;
  // Reference state: 0 benign, 1 contributory, 2 page fault, 3 double fault.
  int rec = 0;
  bit busy = 0;

  always #2.5 clk = ~clk;

  exc_fault_resolver u_dut (
    .clk(clk), .rst(rst), .raise_valid(raise_valid), .raise_vec(raise_vec),
    .raise_err(raise_err), .ext_in(ext_in), .real_mode(real_mode),
    .deliver_done(deliver_done), .dlv_valid(dlv_valid), .dlv_vec(dlv_vec),
    .dlv_err(dlv_err), .dlv_push_err(dlv_push_err), .dlv_restore_ip(dlv_restore_ip),
    .shutdown_req(shutdown_req), .vec_illegal(vec_illegal)
  );

  function automatic int class_of(int v);
    if (v == 8) return 3;
    if (v inside {0, 10, 11, 12, 13}) return 1;
    if (v inside {14, 20}) return 2;
    return 0;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // One clock: drive at the falling edge, predict, compare after the rising edge.
  task automatic step(string tag, bit r, int v, int e, bit x, bit rm, bit d);
    bit ev = 0, esd = 0, eil = 0, epush = 0, erest = 0;
    int evec = 0, eerr = 0, c;
    bit fault, prom;
    @(negedge clk);
    raise_valid = r; raise_vec = 8'(v); raise_err = 16'(e);
    ext_in = x; real_mode = rm; deliver_done = d;
    if (d) begin rec = 0; busy = 0; end
    if (r) begin
      if (v >= 32) eil = 1;
      else begin
        c = class_of(v);
        fault = !(v inside {3, 4, 18});
        if (rec == 3 && fault) esd = 1;
        else begin
          prom = (rec == 1 && c == 1) || (rec == 2 && (c == 1 || c == 2));
          ev = 1;
          if (prom) begin
            evec = 8; eerr = 0; epush = !rm; erest = 1; rec = 3;
          end else begin
            evec = v; erest = fault;
            epush = !rm && (v inside {8, 10, 11, 12, 13, 14, 17});
            if (rm) eerr = 0;
            else if (v == 8 || v == 14) eerr = e & 16'hFFFF;
            else eerr = (e & 16'hFFFE) | int'(x | busy);
            if (c != 0) rec = c;
          end
          busy = 1;
        end
      end
    end
    @(posedge clk); #1;
    chk(tag, "valid", dlv_valid, ev);
    chk(tag, "shutdown", shutdown_req, esd);
    chk(tag, "illegal", vec_illegal, eil);
    if (ev) begin
      chk(tag, "vec", dlv_vec, evec);
      chk(tag, "err", dlv_err, eerr);
      chk(tag, "push", dlv_push_err, epush);
      chk(tag, "restore", dlv_restore_ip, erest);
    end
  endtask

  task automatic done_only();
    step("R9", 0, 0, 0, 0, 0, 1);
  endtask

  initial begin
    #(200000 * 5);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R11", "reset valid", dlv_valid, 0);
    chk("R11", "reset shutdown", shutdown_req, 0);
    chk("R11", "reset illegal", vec_illegal, 0);
    @(negedge clk); rst = 1'b0;
    step("R1", 0, 0, 0, 0, 0, 0);
    // R1 / R6: plain deliveries
    step("R1", 1, 6, 16'h00F0, 0, 0, 0);  done_only();
    step("R6", 1, 3, 0, 0, 0, 0);         done_only();
    step("R6", 1, 18, 0, 0, 0, 0);        done_only();
    step("R4", 1, 17, 16'h0000, 1, 0, 0); done_only();
    // R2 then R7: contributory pair, then fault and trap in double fault
    step("R5", 1, 13, 16'h1234, 1, 0, 0);
    step("R2", 1, 0, 16'hBEEF, 0, 0, 0);
    step("R7", 1, 14, 0, 0, 0, 0);
    step("R7", 1, 3, 16'h0010, 0, 0, 0);
    step("R7", 1, 12, 0, 0, 0, 0);
    done_only();
    // R3 matrix cells
    step("R3", 1, 14, 16'h0003, 0, 0, 0);
    step("R3", 1, 14, 16'h0002, 0, 0, 0);
    done_only();
    step("R3", 1, 14, 16'h0005, 0, 0, 0);
    step("R3", 1, 6, 0, 0, 0, 0);
    step("R3", 1, 11, 16'h0040, 0, 0, 0);
    done_only();
    step("R3", 1, 10, 16'h0006, 0, 0, 0);
    step("R3", 1, 20, 16'h0007, 0, 0, 0);
    done_only();
    // R11 benign keeps class, R5 in-flight bit
    step("R11", 1, 12, 16'h0008, 0, 0, 0);
    step("R5", 1, 17, 16'h0010, 0, 0, 0);
    step("R11", 1, 13, 0, 0, 0, 0);
    done_only();
    // R8 real mode
    step("R8", 1, 13, 16'hFFFF, 1, 1, 0);
    step("R8", 1, 10, 16'hFFFF, 1, 1, 0);
    done_only();
    // R9 same-cycle completion
    step("R9", 1, 13, 16'h0001, 0, 0, 0);
    step("R9", 1, 13, 16'h0001, 0, 0, 1);
    done_only();
    // R10 illegal leaves class
    step("R10", 1, 11, 0, 0, 0, 0);
    step("R10", 1, 40, 0, 0, 0, 0);
    step("R10", 1, 255, 0, 0, 0, 0);
    step("R10", 1, 0, 0, 0, 0, 0);
    done_only();
    step("R1", 0, 0, 0, 0, 0, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule